// File: doc/BRIEF.md
# Chipset Hold Requester

This block sits in a memory controller. It takes the processor's request bus away on behalf of a second bus master and later gives it back. A request from the alternate master raises a hold line toward the processor. The processor answers with an acknowledge once it has floated its request-bus outputs. The controller then switches on its own request-bus drivers, so the shared lines are always driven, and grants the bus to the alternate master. When no request is pending, the block drops hold and turns its drivers off in the same cycle. For three cycles after that it marks the processor's request signals as not yet valid, and in that window it refuses new requests.

The block follows the processor's handshake rules. Hold is never withdrawn before it has been acknowledged. Hold is never raised in a cycle that follows one in which the acknowledge was high. Consecutive alternate-master transfers share one hold period when the request line stays high. If the acknowledge does not arrive within the promised window, a sticky timeout flag is set and the bus stays held until reset.

Top module: `hold_requester`

## Requirements
- R1: After synchronous reset, hold_o, req_drv_en_o, alt_grant_o and ack_timeout_o are low and cpu_req_valid_o is high.
- R2: From idle, hold_o rises at the clock edge where alt_req is high and hlda_i is low. If hlda_i is high at that edge, hold_o stays low and the block stays idle.
- R3: Once raised, hold_o stays high until hlda_i has been sampled high, even if alt_req is withdrawn meanwhile.
- R4: req_drv_en_o goes high at the edge that samples hlda_i high while hold_o is waiting. It stays high only while hold_o is high.
- R5: alt_grant_o is high exactly when the block owns the bus (req_drv_en_o high), hlda_i is high, alt_req is high and alt_done is low. It therefore drops in the cycle where alt_done is high.
- R6: While the block owns the bus and alt_req stays high, several transfers separated by alt_done pulses are served without hold_o dropping.
- R7: An edge in ownership with alt_req low makes hold_o and req_drv_en_o fall together at that edge, unless the timeout flag is set.
- R8: After hold_o falls at edge n, cpu_req_valid_o stays low and alt_req is ignored until edge n+3. At edge n+3 cpu_req_valid_o returns high and the block is idle again.
- R9: Let hold_o rise at edge e. If hlda_i is low at each of edges e+1 to e+7, ack_timeout_o rises at edge e+7. If hlda_i is high at edge e+7, no timeout is flagged.
- R10: Once ack_timeout_o is high it stays high until reset, and hold_o stays high even when alt_req falls during ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_req | input | 1 | Alternate master wants the request bus |
| alt_done | input | 1 | Alternate master finishes the current transfer |
| hlda_i | input | 1 | Hold acknowledge from the processor |
| hold_o | output | 1 | Hold request to the processor |
| alt_grant_o | output | 1 | Grant to the alternate master |
| req_drv_en_o | output | 1 | Output enable of the chipset's request-bus drivers |
| cpu_req_valid_o | output | 1 | Processor request signals may be sampled |
| ack_timeout_o | output | 1 | Sticky flag: acknowledge missing past the window |

## Verification
The vector walk runs one full hold cycle, then a second cycle in which alt_req is withdrawn before the acknowledge. The first shows that a late acknowledge does not cut a hold short. The second shows that ownership continues and ends correctly. An acknowledge that is low during ownership, alt_done pulses with alt_req held high, and requests that arrive during settling or while the acknowledge is still high each separate the grant and re-assertion rules from the simple request-follows-hold behaviour. Directed runs place the acknowledge at the last allowed edge and one edge beyond it, which fixes the timeout boundary to the exact cycle. A final run confirms that the flag keeps the bus held.

// File: rtl/hreq_pkg.sv
package hreq_pkg;

    localparam int unsigned ACK_WINDOW_DEF = 6;
    localparam int unsigned SETTLE_DEF     = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OWN  = 2'd2,
        ST_COOL = 2'd3
    } hreq_state_e;

    typedef struct packed {
        logic hold;
        logic drv_en;
        logic cpu_valid;
    } hreq_drive_t;

    function automatic hreq_drive_t decode_state(hreq_state_e st);
        hreq_drive_t d;
        d.hold      = (st == ST_WAIT) || (st == ST_OWN);
        d.drv_en    = (st == ST_OWN);
        d.cpu_valid = (st == ST_IDLE);
        return d;
    endfunction

endpackage

// File: rtl/hreq_counter.sv
module hreq_counter #(
    parameter int unsigned LIMIT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic hit
);
    localparam int unsigned W = $clog2(LIMIT + 2);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick && (cnt != W'(LIMIT))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = (cnt == W'(LIMIT));

endmodule

// File: rtl/hreq_fsm.sv
module hreq_fsm
    import hreq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        alt_req,
    input  logic        hlda,
    input  logic        ack_hit,
    input  logic        settle_hit,
    output hreq_state_e state,
    output logic        err
);
    hreq_state_e state_nx;
    logic        err_set;

    assign err_set = (state == ST_WAIT) && !hlda && ack_hit;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (alt_req && !hlda) state_nx = ST_WAIT;
            ST_WAIT: if (hlda)             state_nx = ST_OWN;
            ST_OWN:  if (!alt_req && !err) state_nx = ST_COOL;
            ST_COOL: if (settle_hit)       state_nx = ST_IDLE;
            default:                       state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            err   <= 1'b0;
        end else begin
            state <= state_nx;
            err   <= err | err_set;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R10

    AST_ERR_KEEPS_BUS: assert property (@(posedge clk) disable iff (rst)
        err |-> (state == ST_WAIT || state == ST_OWN)); // R10

    AST_IDLE_RESPECTS_ACK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && hlda) |=> (state == ST_IDLE)); // R2

endmodule

// File: rtl/hold_requester.sv
module hold_requester
    import hreq_pkg::*;
#(
    parameter int unsigned ACK_WINDOW = ACK_WINDOW_DEF,
    parameter int unsigned SETTLE     = SETTLE_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic alt_req,
    input  logic alt_done,
    input  logic hlda_i,
    output logic hold_o,
    output logic alt_grant_o,
    output logic req_drv_en_o,
    output logic cpu_req_valid_o,
    output logic ack_timeout_o
);
    localparam int unsigned SETTLE_LIMIT = (SETTLE > 1) ? SETTLE - 1 : 0;

    hreq_state_e state;
    hreq_drive_t drv;
    logic        ack_hit;
    logic        settle_hit;
    logic        err;

    hreq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .alt_req    (alt_req),
        .hlda       (hlda_i),
        .ack_hit    (ack_hit),
        .settle_hit (settle_hit),
        .state      (state),
        .err        (err)
    );

    hreq_counter #(.LIMIT(ACK_WINDOW)) u_ack_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (state != ST_WAIT),
        .tick  ((state == ST_WAIT) && !hlda_i),
        .hit   (ack_hit)
    );

    hreq_counter #(.LIMIT(SETTLE_LIMIT)) u_settle_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (state != ST_COOL),
        .tick  (state == ST_COOL),
        .hit   (settle_hit)
    );

    assign drv             = decode_state(state);
    assign hold_o          = drv.hold;
    assign req_drv_en_o    = drv.drv_en;
    assign cpu_req_valid_o = drv.cpu_valid;
    assign ack_timeout_o   = err;
    assign alt_grant_o     = drv.drv_en && hlda_i && alt_req && !alt_done;

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_o) |-> $past(req_drv_en_o)); // R3

    AST_REASSERT_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_o) |-> !$past(hlda_i)); // R2

    AST_DRV_UNDER_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_drv_en_o |-> hold_o); // R4

    AST_GRANT_OWNED: assert property (@(posedge clk) disable iff (rst)
        alt_grant_o |-> (hlda_i && req_drv_en_o && !alt_done)); // R5

    AST_SETTLE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_o) |-> !cpu_req_valid_o); // R8

    AST_TIMEOUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ack_timeout_o |-> hold_o); // R10

endmodule

// File: tb/test_hold_requester.sv
module test_hold_requester;

    logic clk = 1'b0;
    logic rst;
    logic alt_req, alt_done, hlda_i;
    logic hold_o, alt_grant_o, req_drv_en_o, cpu_req_valid_o, ack_timeout_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    hold_requester i_hold_requester (
        .clk             (clk),
        .rst             (rst),
        .alt_req         (alt_req),
        .alt_done        (alt_done),
        .hlda_i          (hlda_i),
        .hold_o          (hold_o),
        .alt_grant_o     (alt_grant_o),
        .req_drv_en_o    (req_drv_en_o),
        .cpu_req_valid_o (cpu_req_valid_o),
        .ack_timeout_o   (ack_timeout_o)
    );

    // row: {alt_req, alt_done, hlda_i, hold, drv_en, grant, cpu_valid, timeout}
    localparam int NV = 20;
    localparam logic [7:0] VEC [NV] = '{
        8'b000_00010, 8'b100_00010, 8'b100_10000, 8'b101_10000,
        8'b100_11000, 8'b101_11100, 8'b111_11000, 8'b101_11100,
        8'b001_11000, 8'b001_00000, 8'b101_00000, 8'b100_00000,
        8'b101_00010, 8'b100_00010, 8'b001_10000, 8'b001_11000,
        8'b001_00000, 8'b000_00000, 8'b000_00000, 8'b000_00010
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1, 12, 13: return "R2";
            2, 3, 14:     return "R3";
            4:            return "R5";
            5, 6, 7:      return "R6";
            8, 15:        return "R7";
            default:      return "R8";
        endcase
    endfunction

    function automatic logic [4:0] outs();
        return {hold_o, req_drv_en_o, alt_grant_o, cpu_req_valid_o, ack_timeout_o};
    endfunction

    task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (hold,drv,grant,valid,timeout)", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; alt_req = 1'b0; alt_done = 1'b0; hlda_i = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        #2;
        chk("R1", outs(), 5'b00010);
        tick();

        // vector walk
        for (int i = 0; i < NV; i++) begin
            {alt_req, alt_done, hlda_i} = VEC[i][7:5];
            #2;
            chk(tag_of(i), outs(), VEC[i][4:0]);
            tick();
        end

        // acknowledge at the last allowed edge: no timeout (R9)
        do_reset();
        alt_req = 1'b1;
        tick();                                   // edge e: hold rises
        for (int k = 1; k <= 6; k++) tick();      // edges e+1..e+6 without ack
        hlda_i = 1'b1;
        tick();                                   // edge e+7 samples ack
        chk("R9", outs(), 5'b11100);
        alt_req = 1'b0;
        tick();
        hlda_i = 1'b0;
        #2;
        chk("R7", outs(), 5'b00000);

        // acknowledge missing: timeout at edge e+7 (R9), sticky (R10)
        do_reset();
        alt_req = 1'b1;
        tick();                                   // edge e
        for (int k = 1; k <= 6; k++) tick();
        chk("R9", outs(), 5'b10000);              // after e+6, no flag yet
        alt_req = 1'b0;                           // request withdrawn: hold stays (R3)
        tick();                                   // edge e+7
        chk("R9", outs(), 5'b10001);
        for (int k = 0; k < 4; k++) tick();
        chk("R10", outs(), 5'b10001);
        hlda_i = 1'b1;
        tick();                                   // ack arrives, ownership
        chk("R10", outs(), 5'b11001);             // alt_req low: no grant
        for (int k = 0; k < 3; k++) tick();
        chk("R10", outs(), 5'b11001);             // no release while flagged
        alt_req = 1'b1;
        #2;
        chk("R5", outs(), 5'b11101);

        do_reset();
        #2;
        chk("R1", outs(), 5'b00010);

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule